// File: doc/BRIEF.md
# Pipelined SRAM Access Controller

This block is the synchronous front end of a small on-chip static memory. On every rising clock edge it samples an address, an active-low chip select, active-low write controls and write data. A sampled write commits to the array on the next edge, into the byte lanes it selects. A sampled read places the addressed word in an output register one edge later. The shared data bus is split into a write-data input, a read-data output and a drive-enable output. A surrounding pad ring or bus model uses the drive enable to decide when the read data may be placed on the wires.

The drive enable is pipelined alongside the read data. A mode input selects how quickly a deselect turns the drivers off. In early mode the drivers drop one stage ahead of read data. In late mode a deselect travels the same pipeline as a read. An asynchronous output-enable input masks the drivers at once. A sleep input puts the block in a standby state that keeps the array contents, ignores new cycles and holds the drivers off.

Top module: `sram_pipe_front`

## Requirements
- R1: A read is an enabled cycle (`cs_n_i`=0, `sleep_i`=0) with `gw_n_i`=1 and `bwe_n_i`=1. When its address is sampled at edge N, the stored word is on `rdata_o` with `rdata_oe_o`=1 after edge N+1, provided the next cycle does not cut it off (R6).
- R2: Byte lane i is bits [8i+7:8i] of the word. In a write cycle without global write, lane i is stored only when `bwe_n_i`=0 and `bw_n_i[i]`=0 are sampled together.
- R3: `gw_n_i`=0 in an enabled cycle stores all four lanes, whatever `bwe_n_i` and `bw_n_i` are.
- R4: An enabled cycle with `bwe_n_i`=0, `gw_n_i`=1 and all `bw_n_i` bits at 1 is a write cycle that changes no stored data.
- R5: A write cycle sampled at edge N leaves `rdata_oe_o`=0 after edge N+1.
- R6: With `dcd_sel_i`=0, a deselect (`cs_n_i`=1) sampled at edge N forces `rdata_oe_o`=0 after edge N, even if a read was sampled at edge N-1.
- R7: With `dcd_sel_i`=1, a read sampled at edge N-1 is still driven after edge N when a deselect is sampled at N. The deselect turns the drivers off after edge N+1.
- R8: `oe_n_i`=1 forces `rdata_oe_o`=0 in the same cycle, without waiting for a clock edge.
- R9: While `sleep_i`=1, `rdata_oe_o`=0. Reads and writes sampled with `sleep_i`=1 are ignored, and stored data is kept.
- R10: The first edge with `sleep_i`=0 samples a cycle normally, so a read sampled there is driven after the following edge.
- R11: After reset, `rdata_oe_o`=0 until a read has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline registers |
| addr_i | input | 6 | Word address, sampled each edge |
| cs_n_i | input | 1 | Active-low chip select; high is a deselect cycle |
| gw_n_i | input | 1 | Active-low global write of all lanes |
| bwe_n_i | input | 1 | Active-low byte-write enable |
| bw_n_i | input | 4 | Active-low per-lane write selects |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dcd_sel_i | input | 1 | 1 selects late (two-stage) deselect, 0 early deselect |
| sleep_i | input | 1 | Standby request, active high |
| wdata_i | input | 32 | Write data, sampled with the address |
| rdata_o | output | 32 | Registered read data |
| rdata_oe_o | output | 1 | Drive enable for the read data |

## Verification
The bench runs a full-word fill of the array with global write. It then applies single-lane and two-lane byte writes over a known word, which shows whether each lane is gated on its own select. A global write with every lane select off tells the override apart from the lane path, and a byte-write enable with no lane selected tells an empty write apart from a read. A read followed by a deselect is run in both modes, which separates the early and late turn-off edges. A read followed by a write confirms that a write slot silences the drivers. A sleep window with write and read attempts checks that contents are retained and that operation resumes on the first edge after release. Finally, a long run of mixed random cycles with mode changes is compared against a behavioural model on every clock.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_READ  = 2'd1,
    SLOT_WRITE = 2'd2
  } slot_e;
endpackage

// File: rtl/sram_wctl.sv
module sram_wctl #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic             is_wr,
  output logic [LANES-1:0] mask
);
  function automatic logic [LANES-1:0] lane_mask(input logic g_n, input logic e_n,
                                                 input logic [LANES-1:0] b_n);
    if (!g_n)      return '1;
    else if (!e_n) return ~b_n;
    else           return '0;
  endfunction

  function automatic logic write_cycle(input logic g_n, input logic e_n);
    return !g_n || !e_n;
  endfunction

  assign mask  = lane_mask(gw_n, bwe_n, bw_n);
  assign is_wr = write_cycle(gw_n, bwe_n);
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int AW = 6,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sram_oe_pipe.sv
module sram_oe_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic dcd_sel,
  input  logic sleep,
  input  logic cap_desel,
  input  logic slot_rd,
  input  logic slot_wr,
  output logic drv_q
);
  logic drv_d;
  logic cut_early;

  assign cut_early = !dcd_sel && cap_desel;

  always_comb begin
    if (sleep)        drv_d = 1'b0;
    else if (dcd_sel) drv_d = slot_rd;
    else              drv_d = slot_rd && !cut_early;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_d;
  end

  assert_sleep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !drv_q);
  assert_scd_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dcd_sel && cap_desel) |=> !drv_q);
  assert_dcd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_sel && slot_rd && !sleep) |=> drv_q);
  assert_wr_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |=> !drv_q);
endmodule

// File: rtl/sram_pipe_front.sv
module sram_pipe_front #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr_i,
  input  logic                cs_n_i,
  input  logic                gw_n_i,
  input  logic                bwe_n_i,
  input  logic [LANES-1:0]    bw_n_i,
  input  logic                oe_n_i,
  input  logic                dcd_sel_i,
  input  logic                sleep_i,
  input  logic [LANES*BW-1:0] wdata_i,
  output logic [LANES*BW-1:0] rdata_o,
  output logic                rdata_oe_o
);
  import sram_pipe_pkg::*;
  localparam int DW = LANES * BW;

  logic             in_wr;
  logic [LANES-1:0] in_mask;
  logic             cap_desel;
  logic             cap_skip;

  slot_e            slot_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    arr_rd;
  logic [DW-1:0]    rdata_q;
  logic             drv_q;
  logic             slot_rd;
  logic             slot_wr;

  sram_wctl #(.LANES(LANES)) u_wctl (
    .gw_n(gw_n_i), .bwe_n(bwe_n_i), .bw_n(bw_n_i),
    .is_wr(in_wr), .mask(in_mask)
  );

  assign cap_desel = cs_n_i && !sleep_i;
  assign cap_skip  = cs_n_i || sleep_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= SLOT_IDLE;
      mask_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_i;
      data_q <= wdata_i;
      if (cap_skip) begin
        slot_q <= SLOT_IDLE;
        mask_q <= '0;
      end else begin
        slot_q <= in_wr ? SLOT_WRITE : SLOT_READ;
        mask_q <= in_mask;
      end
    end
  end

  assign slot_rd = (slot_q == SLOT_READ);
  assign slot_wr = (slot_q == SLOT_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane #(.AW(AW), .BW(BW)) u_lane (
      .clk(clk),
      .we(slot_wr && mask_q[g]),
      .addr(addr_q),
      .wdata(data_q[g*BW +: BW]),
      .rdata(arr_rd[g*BW +: BW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (slot_rd) rdata_q <= arr_rd;
  end

  sram_oe_pipe u_oe (
    .clk(clk), .rst_n(rst_n), .dcd_sel(dcd_sel_i), .sleep(sleep_i),
    .cap_desel(cap_desel), .slot_rd(slot_rd), .slot_wr(slot_wr), .drv_q(drv_q)
  );

  assign rdata_o    = rdata_q;
  assign rdata_oe_o = drv_q && !oe_n_i && !sleep_i;

  assert_gw_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && !$past(gw_n_i)) |-> (&mask_q));
  assert_byte_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && $past(gw_n_i)) |->
      ((mask_q & ($past(bw_n_i) | {LANES{$past(bwe_n_i)}})) == '0));
  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_i) |-> (slot_q == SLOT_IDLE));
  assert_oe_async_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !rdata_oe_o);
endmodule

// File: tb/tb_sram_pipe_front.sv
module tb_sram_pipe_front;
  localparam int CLK_P = 10;
  localparam int AW = 6, LANES = 4, BW = 8, DW = LANES * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, dcd = 1'b0, sleep = 1'b0;
  logic [LANES-1:0] bw_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  sram_pipe_front dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_n_i(cs_n), .gw_n_i(gw_n),
    .bwe_n_i(bwe_n), .bw_n_i(bw_n), .oe_n_i(oe_n), .dcd_sel_i(dcd),
    .sleep_i(sleep), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string req = "R11";

  logic [DW-1:0] m_mem [DEPTH];
  bit m_rd = 0, m_wr = 0, m_drv = 0;
  logic [LANES-1:0] m_mask = '0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0, m_out = '0;

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit desel;
    bit wr_now;
    logic [LANES-1:0] mk;
    desel = !sleep && cs_n;
    if (m_rd) m_out = m_mem[m_addr];
    if (m_wr)
      for (int i = 0; i < LANES; i++)
        if (m_mask[i]) m_mem[m_addr][i*BW +: BW] = m_data[i*BW +: BW];
    if (sleep)    m_drv = 0;
    else if (dcd) m_drv = m_rd;
    else          m_drv = m_rd && !desel;
    wr_now = (gw_n == 1'b0) || (bwe_n == 1'b0);
    for (int i = 0; i < LANES; i++)
      mk[i] = (gw_n == 1'b0) || ((bwe_n == 1'b0) && (bw_n[i] == 1'b0));
    if (sleep || cs_n) begin
      m_rd = 0; m_wr = 0; m_mask = '0;
    end else begin
      m_wr = wr_now; m_rd = !wr_now; m_mask = mk;
      m_addr = addr; m_data = wdata;
    end
  endtask

  task automatic compare();
    bit exp_oe;
    exp_oe = m_drv && !oe_n && !sleep;
    check(rdata_oe == exp_oe, "drive-enable", DW'(rdata_oe), DW'(exp_oe));
    if (exp_oe) check(rdata == m_out, "read-data", rdata, m_out);
  endtask

  task automatic cyc(input logic c, input logic g, input logic be,
                     input logic [LANES-1:0] b, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    cs_n = c; gw_n = g; bwe_n = be; bw_n = b; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    compare();
  endtask

  task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b1, '1, a, d);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cyc(1'b0, 1'b1, 1'b1, '1, a, '0);
  endtask
  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, '1, '0, '0);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    req = "R11";
    check(rdata_oe == 1'b0, "reset drive-enable", DW'(rdata_oe), '0);
    rst_n = 1'b1;
    idle();
    check(rdata_oe == 1'b0, "post-reset drive-enable", DW'(rdata_oe), '0);

    // fill array (R3 global write path)
    req = "R3";
    for (int a = 0; a < DEPTH; a++) wr_all(AW'(a), DW'(32'h0101_0101 * (a + 1)));

    // R1: read latency, late mode
    req = "R1";
    dcd = 1'b1;
    rd(6'd12); rd(6'd12);
    check(rdata_oe && rdata == DW'(32'h0101_0101 * 13), "read word", rdata,
          DW'(32'h0101_0101 * 13));

    // R2: byte lanes 0 and 2
    req = "R2";
    wr_all(6'd5, 32'h1122_3344);
    cyc(1'b0, 1'b1, 1'b0, 4'b1010, 6'd5, 32'hAABB_CCDD);
    rd(6'd5); rd(6'd5);
    check(rdata == 32'h11BB_33DD, "lanes 0,2", rdata, 32'h11BB_33DD);
    cyc(1'b0, 1'b1, 1'b0, 4'b0111, 6'd5, 32'h99EE_EEEE);
    rd(6'd5); rd(6'd5);
    check(rdata == 32'h99BB_33DD, "lane 3", rdata, 32'h99BB_33DD);

    // R3: global write overrides lane selects all off
    req = "R3";
    cyc(1'b0, 1'b0, 1'b0, 4'b1111, 6'd9, 32'hCAFE_F00D);
    rd(6'd9); rd(6'd9);
    check(rdata == 32'hCAFE_F00D, "global write", rdata, 32'hCAFE_F00D);

    // R4: byte-write enable without lanes changes nothing
    req = "R4";
    cyc(1'b0, 1'b1, 1'b0, 4'b1111, 6'd9, 32'h0000_0000);
    rd(6'd9); rd(6'd9);
    check(rdata == 32'hCAFE_F00D, "empty write", rdata, 32'hCAFE_F00D);

    // R5: write slot silences drivers
    req = "R5";
    rd(6'd3);
    wr_all(6'd4, 32'h4444_4444);
    check(rdata_oe == 1'b1, "read before write", DW'(rdata_oe), 1);
    idle();
    check(rdata_oe == 1'b0, "write slot", DW'(rdata_oe), 0);

    // R6: early deselect
    req = "R6";
    dcd = 1'b0;
    rd(6'd7); idle();
    check(rdata_oe == 1'b0, "early deselect", DW'(rdata_oe), 0);

    // R7: late deselect
    req = "R7";
    dcd = 1'b1;
    rd(6'd7); idle();
    check(rdata_oe == 1'b1 && rdata == DW'(32'h0101_0101 * 8), "late hold", rdata,
          DW'(32'h0101_0101 * 8));
    idle();
    check(rdata_oe == 1'b0, "late off", DW'(rdata_oe), 0);

    // R8: asynchronous output enable
    req = "R8";
    rd(6'd2); rd(6'd2);
    oe_n = 1'b1; #1;
    check(rdata_oe == 1'b0, "oe high", DW'(rdata_oe), 0);
    oe_n = 1'b0; #1;
    check(rdata_oe == 1'b1, "oe low", DW'(rdata_oe), 1);

    // R9: sleep ignores cycles and keeps data
    req = "R9";
    sleep = 1'b1;
    wr_all(6'd5, 32'hDEAD_BEEF);
    check(rdata_oe == 1'b0, "sleep drive", DW'(rdata_oe), 0);
    rd(6'd5); rd(6'd5);
    check(rdata_oe == 1'b0, "sleep read", DW'(rdata_oe), 0);

    // R10: resume on first edge after release
    req = "R10";
    sleep = 1'b0;
    rd(6'd5); rd(6'd5);
    check(rdata_oe == 1'b1 && rdata == 32'h99BB_33DD, "resume read", rdata, 32'h99BB_33DD);

    // mixed random traffic against the model
    req = "R1";
    for (int k = 0; k < 600; k++) begin
      if (k % 50 == 0) dcd = $urandom_range(1);
      sleep = ($urandom_range(19) == 0);
      cyc($urandom_range(3) == 0, $urandom_range(5) != 0, $urandom_range(2) != 0,
          LANES'($urandom), AW'($urandom), DW'($urandom));
    end
    sleep = 1'b0;
    idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule